// File: doc/BRIEF.md
# Victim Line Buffer

This block is a four-entry, fully associative store that keeps cache lines recently thrown out of a direct-mapped cache. Whenever the main array discards a line, that line's address and data go in on the eviction port. When the main array misses, its controller presents the missing line address on the lookup port. One cycle later the block reports whether any entry holds that line, and returns the line's data if one does.

A hit is resolved as a swap. The line the main array is about to overwrite is offered together with the lookup, and it takes over the slot of the matching entry. If no line is offered, the matching entry is freed instead. When both the main array and every entry miss, the block raises a forward request that carries the line address for the next memory level.

Each entry has its own tag register and comparator. A new eviction goes into the lowest-numbered free entry if there is one. When every entry is occupied, it replaces the entry whose contents were written longest ago.

Top module: `victim_buffer`

## Requirements
- R1: After reset, no entry is valid. Every lookup misses, and `resp_valid` and `fwd_valid` are low until a lookup is made.
- R2: A lookup accepted on one rising edge gives `resp_valid` high for exactly the following cycle. A cycle without a lookup gives `resp_valid` low in the next cycle.
- R3: After a line is written through the eviction port, a lookup of its address reports `resp_hit`=1 and returns exactly the data that was stored. Any of the four entries may match any address.
- R4: The buffer holds four lines at once. An eviction into a full buffer replaces the entry written least recently, counting both evictions and swaps as writes. All other entries are kept.
- R5: While any entry is free, an eviction takes the lowest-numbered free entry and displaces no valid line.
- R6: A lookup hit with `swap_valid`=1 stores `swap_addr` and `swap_data` into the matching entry. After that, the old address misses and the swapped-in address hits with the swapped-in data. The number of valid entries does not change.
- R7: A lookup hit with `swap_valid`=0 frees the matching entry, so the next lookup of that address misses.
- R8: `fwd_valid` rises in the response cycle only when the lookup missed, with `fwd_addr` equal to the looked-up address. A miss leaves every entry unchanged.
- R9: When `evict_valid` and `lookup_valid` are both high in the same cycle, the lookup is served and the eviction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | A line discarded by the main cache is presented |
| evict_addr | input | ADDR_W | Line address of the discarded line |
| evict_data | input | DATA_W | Data of the discarded line |
| lookup_valid | input | 1 | Main-cache miss; search the buffer |
| lookup_addr | input | ADDR_W | Line address being searched |
| swap_valid | input | 1 | The main cache offers its displaced line for a swap |
| swap_addr | input | ADDR_W | Line address of the displaced line |
| swap_data | input | DATA_W | Data of the displaced line |
| resp_valid | output | 1 | Lookup response cycle |
| resp_hit | output | 1 | The searched line was found |
| resp_data | output | DATA_W | Line data on a hit |
| fwd_valid | output | 1 | Request to the next level (both levels missed) |
| fwd_addr | output | ADDR_W | Line address for the next level |

## Verification
The bench goes after replacement order when the buffer is full. A design that replaced by slot number or by last access, rather than by write age, would drop a line that is still young, and a later lookup of that line would miss.

It frees an entry with a swap-less hit and then evicts. A design that ignored free slots would push out the oldest valid line instead of filling the hole.

Swaps are checked in both directions. A slip there would either leave the old address still hitting or lose the swapped-in data.

Same-cycle eviction and lookup are also exercised. A design that honoured both would later hit on a line that the controller considers dropped.

// File: rtl/vb_pkg.sv
`timescale 1ns/1ps
package vb_pkg;
  // Index of the lowest set bit; 0 when the vector is empty.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/vb_tag_array.sv
`timescale 1ns/1ps
module vb_tag_array #(
  parameter int ADDR_W  = 8,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_slot,
  input  logic [ADDR_W-1:0]  wr_tag,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_slot,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec
);
  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  assign valid_vec = valid_q;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (tag_q[g] == cmp_addr);

      always_ff @(posedge clk) begin
        if (wr_en && wr_slot == IDX_W'(g)) tag_q[g] <= wr_tag;
      end

      always_ff @(posedge clk) begin
        if (rst) valid_q[g] <= 1'b0;
        else if (wr_en && wr_slot == IDX_W'(g)) valid_q[g] <= 1'b1;
        else if (clr_en && clr_slot == IDX_W'(g)) valid_q[g] <= 1'b0;
      end
    end
  endgenerate

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R3
endmodule

// File: rtl/vb_repl.sv
`timescale 1ns/1ps
module vb_repl #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_slot,
  output logic [IDX_W-1:0]   pick_slot
);
  // Write-age rank per entry: 0 = newest, ENTRIES-1 = oldest.
  logic [IDX_W-1:0] rank_q [ENTRIES];
  logic all_valid;

  assign all_valid = &valid_vec;

  always_comb begin
    pick_slot = '0;
    if (!all_valid) begin
      pick_slot = IDX_W'(vb_pkg::lowest_set(32'(~valid_vec)));
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_q[i] == IDX_W'(ENTRIES - 1)) pick_slot = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (upd_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == upd_slot) rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[upd_slot]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  AST_PICK_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    !all_valid |-> !valid_vec[pick_slot]); // R5
endmodule

// File: rtl/vb_line_store.sv
`timescale 1ns/1ps
module vb_line_store #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/victim_buffer.sv
`timescale 1ns/1ps
module victim_buffer #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              swap_valid,
  input  logic [ADDR_W-1:0] swap_addr,
  input  logic [DATA_W-1:0] swap_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic [ENTRIES-1:0] valid_vec, match_vec;
  logic [IDX_W-1:0]   hit_slot, pick_slot, wr_slot;
  logic               any_hit, do_ins, do_swap, do_free, wr_en;
  logic [ADDR_W-1:0]  wr_tag;
  logic [DATA_W-1:0]  wr_data;

  assign any_hit  = |match_vec;
  assign hit_slot = IDX_W'(vb_pkg::lowest_set(32'(match_vec)));
  assign do_ins   = evict_valid && !lookup_valid;
  assign do_swap  = lookup_valid && any_hit && swap_valid;
  assign do_free  = lookup_valid && any_hit && !swap_valid;
  assign wr_en    = do_ins || do_swap;
  assign wr_slot  = do_swap ? hit_slot : pick_slot;
  assign wr_tag   = do_swap ? swap_addr : evict_addr;
  assign wr_data  = do_swap ? swap_data : evict_data;

  vb_tag_array #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_tags (
    .clk(clk), .rst(rst), .cmp_addr(lookup_addr),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_tag(wr_tag),
    .clr_en(do_free), .clr_slot(hit_slot),
    .valid_vec(valid_vec), .match_vec(match_vec)
  );

  vb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk(clk), .rst(rst), .valid_vec(valid_vec),
    .upd_en(wr_en), .upd_slot(wr_slot), .pick_slot(pick_slot)
  );

  vb_line_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_slot), .wdata(wr_data),
    .re(lookup_valid), .raddr(hit_slot), .rdata(resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_addr   <= '0;
    end else begin
      resp_valid <= lookup_valid;
      resp_hit   <= lookup_valid && any_hit;
      fwd_valid  <= lookup_valid && !any_hit;
      if (lookup_valid) fwd_addr <= lookup_addr;
    end
  end

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(lookup_valid)); // R2
  AST_FWD_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (resp_valid && !resp_hit)); // R8
  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    do_swap |=> $countones(valid_vec) == $past($countones(valid_vec))); // R6
  AST_FREE_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    do_free |=> $countones(valid_vec) + 1 == $past($countones(valid_vec))); // R7
endmodule

// File: tb/tb_victim_buffer.sv
`timescale 1ns/1ps
module tb_victim_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evict_valid = 1'b0, lookup_valid = 1'b0, swap_valid = 1'b0;
  logic [7:0]  evict_addr = '0, lookup_addr = '0, swap_addr = '0;
  logic [31:0] evict_data = '0, swap_data = '0;
  logic resp_valid, resp_hit, fwd_valid;
  logic [31:0] resp_data;
  logic [7:0]  fwd_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0]  tag_m [4];
  logic [31:0] dat_m [4];
  bit          val_m [4];
  int          stamp_m [4];
  int          ctr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  victim_buffer dut (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .swap_valid(swap_valid), .swap_addr(swap_addr), .swap_data(swap_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [7:0] a);
    for (int i = 0; i < 4; i++) if (val_m[i] && tag_m[i] == a) return i;
    return -1;
  endfunction

  task automatic model_insert(input logic [7:0] a, input logic [31:0] d);
    int s = -1;
    for (int i = 3; i >= 0; i--) if (!val_m[i]) s = i;
    if (s < 0) begin
      s = 0;
      for (int i = 1; i < 4; i++) if (stamp_m[i] < stamp_m[s]) s = i;
    end
    tag_m[s] = a; dat_m[s] = d; val_m[s] = 1; ctr++; stamp_m[s] = ctr;
  endtask

  // One cycle of stimulus, then check the registered response.
  task automatic op(input bit ev, input logic [7:0] ea, input logic [31:0] ed,
                    input bit lk, input logic [7:0] la,
                    input bit sv, input logic [7:0] sa, input logic [31:0] sd,
                    input string req);
    int hi;
    hi = find(la);
    @(negedge clk);
    evict_valid = ev; evict_addr = ea; evict_data = ed;
    lookup_valid = lk; lookup_addr = la;
    swap_valid = sv; swap_addr = sa; swap_data = sd;
    @(negedge clk);
    evict_valid = 0; lookup_valid = 0; swap_valid = 0;
    if (lk) begin
      chk(resp_valid == 1'b1, "R2 resp_valid", 32'(resp_valid), 32'd1);
      chk(resp_hit == (hi >= 0), req, 32'(resp_hit), 32'(hi >= 0));
      if (hi >= 0) chk(resp_data == dat_m[hi], "R3 data", resp_data, dat_m[hi]);
      chk(fwd_valid == (hi < 0), "R8 fwd_valid", 32'(fwd_valid), 32'(hi < 0));
      if (hi < 0) chk(fwd_addr == la, "R8 fwd_addr", 32'(fwd_addr), 32'(la));
      if (hi >= 0) begin
        if (sv) begin
          tag_m[hi] = sa; dat_m[hi] = sd; ctr++; stamp_m[hi] = ctr;
        end else begin
          val_m[hi] = 0;
        end
      end
    end else begin
      chk(resp_valid == 1'b0, "R2 idle", 32'(resp_valid), 32'd0);
      if (ev) model_insert(ea, ed);
    end
  endtask

  function automatic logic [31:0] dgen(input logic [7:0] a);
    return (32'(ctr) * 32'h9E3779B9) ^ {24'h5A5A00, a};
  endfunction

  task automatic evict(input logic [7:0] a);
    op(1, a, dgen(a), 0, 8'h00, 0, 8'h00, 32'h0, "R3");
  endtask

  task automatic look(input logic [7:0] a, input string req);
    op(0, 8'h00, 32'h0, 1, a, 0, 8'h00, 32'h0, req);
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin val_m[i] = 0; stamp_m[i] = 0; tag_m[i] = 0; dat_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(resp_valid == 0, "R1 resp_valid after reset", 32'(resp_valid), 0);
    chk(fwd_valid == 0, "R1 fwd_valid after reset", 32'(fwd_valid), 0);
    for (int a = 0; a < 16; a++) look(8'(a), "R1 empty miss");

    // Fill four slots, then check each with a swap (R3, R6)
    for (int a = 0; a < 4; a++) evict(8'(8'h10 + a));
    for (int a = 0; a < 4; a++)
      op(0, 0, 0, 1, 8'(8'h10 + a), 1, 8'(8'h20 + a), dgen(8'(8'h20 + a)), "R3 hit after evict");
    for (int a = 0; a < 4; a++) look(8'(8'h10 + a), "R6 old address misses");
    // Swapped lines: write ages now 20,21,22,23 in that order.
    evict(8'h30);                        // replaces 20 (R4)
    look(8'h20, "R4 oldest replaced");
    op(0, 0, 0, 1, 8'h21, 1, 8'h21, 32'hCAFE0021, "R4 younger kept");
    // 21 rewritten; now oldest is 22
    evict(8'h31);
    look(8'h22, "R4 oldest after rewrite");
    op(0, 0, 0, 1, 8'h23, 1, 8'h23, 32'h00BEEF23, "R4 kept");
    // Free one slot (R7) then evict (R5): no valid line displaced
    look(8'h30, "R7 hit frees");
    look(8'h30, "R7 freed misses");
    evict(8'h32);
    op(0, 0, 0, 1, 8'h21, 1, 8'h21, 32'h11112121, "R5 free slot used first");
    op(0, 0, 0, 1, 8'h31, 1, 8'h31, 32'h22223131, "R5 kept");
    // Same-cycle eviction dropped (R9)
    op(1, 8'h40, 32'hDEAD0040, 1, 8'h55, 0, 0, 0, "R9 lookup served");
    look(8'h40, "R9 dropped eviction misses");
    // Miss leaves contents intact (R8)
    op(0, 0, 0, 1, 8'h23, 1, 8'h23, 32'h33332323, "R8 after miss still hits");

    // Pseudo-random sweep over a 16-line pool
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, sa;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {4'h6, lfsr[3:0]};
      sa = {4'h6, lfsr[7:4]};
      while (find(sa) >= 0 || sa == a) sa = {4'h6, sa[3:0] + 4'd1};
      case (lfsr[9:8])
        2'd0, 2'd1: begin
          while (find(a) >= 0) a = {4'h6, a[3:0] + 4'd1};
          evict(a);
        end
        2'd2: op(0, 0, 0, 1, a, lfsr[10], sa, dgen(sa), "R6 sweep lookup");
        default: begin
          logic [7:0] ea;
          ea = sa;
          op(1, ea, dgen(ea), 1, a, 0, 0, 0, "R9 sweep lookup");
        end
      endcase
    end
    for (int a = 0; a < 16; a++) look(8'(8'h60 + a), "R3 final scan");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1;
    $finish;
  end
endmodule